// File: doc/BRIEF.md
# Compare Output Waveform Unit with Forced-Match Strobes

This block drives the two output-compare pins (channel A and channel B) of a 16-bit timer. Each cycle the counter advances (`cnt_tick` high), the block compares the counter value with each channel's compare register. On a hit it applies that channel's 2-bit pin action to its waveform output. It also emits a one-cycle match flag for the interrupt logic. When channel A hits in clear-on-compare mode, it emits a one-cycle request to clear the counter. PWM waveform generation, the counter and the prescaler sit outside this block.

Software can also force a match through a byte-wide control register. Bits 7 and 6 are write-only strobes for channel A and channel B. A strobe drives the pin exactly as a real hit would, using the pin action selected in that cycle. It raises no flag, requests no counter clear, and has no effect while a PWM mode is selected. Every bit of the register reads back as zero.

The block carries no data stream, so it has no valid/ready handshake. All pins are plain control and status signals sampled on the rising clock edge. The register write port takes a write on any cycle and cannot apply back-pressure.

Top module: `oc_wave_unit`

## Requirements
- R1: After reset, both waveform outputs, both match flags and the counter-clear request are 0.
- R2: When `cnt_tick` is 1 and `cnt_val` equals a channel's compare value, that channel's match flag is 1 for exactly the following cycle.
- R3: The 2-bit pin action per channel is 00 = no change, 01 = toggle, 10 = drive 0, 11 = drive 1. A hit applies the action so that the pin shows the new level from the following cycle.
- R4: A write with `ctl_wdata[7]` = 1 forces channel A, and a write with `ctl_wdata[6]` = 1 forces channel B. The pin changes from the following cycle, using the action present on the same cycle as the write.
- R5: A forced match never raises the channel's match flag.
- R6: A forced match on channel A never raises `ctc_clr`, even in clear-on-compare mode.
- R7: While `pwm_mode` is 1, force strobes leave both pins unchanged.
- R8: `ctl_rdata` reads as 0 at all times, whatever was written.
- R9: `ctc_clr` is 1 for one cycle after a real channel A hit when `ctc_mode` is 1 and `pwm_mode` is 0. A channel B hit never raises it.
- R10: A force and a real hit on the same channel in the same cycle apply the action only once, and the flag is raised.
- R11: In PWM mode a real hit still raises the match flag but leaves the pin unchanged and raises no counter clear.
- R12: With `cnt_tick` at 0, an equal counter and compare value cause no flag, no pin change and no clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | Counter advances this cycle |
| cnt_val | input | 16 | Current counter value |
| cmp_a | input | 16 | Channel A compare value |
| cmp_b | input | 16 | Channel B compare value |
| com_a | input | 2 | Channel A pin action |
| com_b | input | 2 | Channel B pin action |
| pwm_mode | input | 1 | A PWM waveform mode is selected |
| ctc_mode | input | 1 | Clear-on-compare with channel A as TOP |
| ctl_wr | input | 1 | Write strobe for the force register |
| ctl_wdata | input | 8 | Write data; bit 7 forces A, bit 6 forces B |
| ctl_rdata | output | 8 | Read data of the force register |
| wave_a | output | 1 | Channel A waveform pin |
| wave_b | output | 1 | Channel B waveform pin |
| match_a | output | 1 | Channel A compare-match flag pulse |
| match_b | output | 1 | Channel B compare-match flag pulse |
| ctc_clr | output | 1 | Counter-clear request |

## Verification
The pin level is the only state the block holds. A wrong level shows up on `wave_a` or `wave_b` one cycle after the hit or strobe that caused it. The error then persists until a clear or set action overwrites it, so a missed or doubled toggle shows on every later sample. Flag and clear errors are one-cycle pulses and must be checked in the cycle that follows each stimulus. The bench sweeps every pair of pin actions across both mode bits and six stimulus kinds, and after every vector it compares all pins against an arithmetic model.

// File: rtl/oc_wave_pkg.sv
package oc_wave_pkg;

  typedef enum logic [1:0] {
    PIN_KEEP   = 2'b00,
    PIN_TOGGLE = 2'b01,
    PIN_LOW    = 2'b10,
    PIN_HIGH   = 2'b11
  } pin_act_e;

  function automatic logic pin_next(input logic [1:0] act, input logic cur);
    case (pin_act_e'(act))
      PIN_TOGGLE: pin_next = ~cur;
      PIN_LOW:    pin_next = 1'b0;
      PIN_HIGH:   pin_next = 1'b1;
      default:    pin_next = cur;
    endcase
  endfunction

endpackage

// File: rtl/oc_force_decode.sv
module oc_force_decode #(
  parameter int DATA_W    = 8,
  parameter int NCH       = 2,
  parameter int FORCE_MSB = 7
) (
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pwm_mode,
  output logic [NCH-1:0]    force_req,
  output logic [DATA_W-1:0] rdata
);
  // channel i strobe lives at bit FORCE_MSB-i; strobes are write-only
  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign force_req[i] = wr && wdata[FORCE_MSB-i] && !pwm_mode;
  end

  assign rdata = '0;
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_wave_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic [1:0]       act,
  input  logic             pwm_mode,
  input  logic             force_req,
  output logic             hit,
  output logic             wave,
  output logic             flag
);
  logic apply;

  assign hit   = tick && (cnt == cmp);
  assign apply = (hit || force_req) && !pwm_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wave <= 1'b0;
      flag <= 1'b0;
    end else begin
      flag <= hit;
      if (apply) wave <= pin_next(act, wave);
    end
  end

  assert_hit_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
  assert_force_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (force_req && !hit) |=> !flag);
  assert_pwm_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_mode |=> $stable(wave));
  assert_toggle_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit || force_req) && !pwm_mode && act == 2'b01) |=> (wave != $past(wave)));
  assert_set_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit || force_req) && !pwm_mode && act == 2'b11) |=> wave);
endmodule

// File: rtl/oc_wave_unit.sv
module oc_wave_unit #(
  parameter int CNT_W     = 16,
  parameter int DATA_W    = 8,
  parameter int FORCE_MSB = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_tick,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic [CNT_W-1:0]  cmp_a,
  input  logic [CNT_W-1:0]  cmp_b,
  input  logic [1:0]        com_a,
  input  logic [1:0]        com_b,
  input  logic              pwm_mode,
  input  logic              ctc_mode,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] ctl_wdata,
  output logic [DATA_W-1:0] ctl_rdata,
  output logic              wave_a,
  output logic              wave_b,
  output logic              match_a,
  output logic              match_b,
  output logic              ctc_clr
);
  localparam int NCH = 2;

  logic [NCH-1:0]       force_req, hit, wave, flag;
  logic [CNT_W-1:0]     cmp_arr [NCH];
  logic [1:0]           act_arr [NCH];

  assign cmp_arr[0] = cmp_a;
  assign cmp_arr[1] = cmp_b;
  assign act_arr[0] = com_a;
  assign act_arr[1] = com_b;

  oc_force_decode #(.DATA_W(DATA_W), .NCH(NCH), .FORCE_MSB(FORCE_MSB)) u_dec (
    .wr(ctl_wr), .wdata(ctl_wdata), .pwm_mode(pwm_mode),
    .force_req(force_req), .rdata(ctl_rdata)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    oc_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .cnt(cnt_val),
      .cmp(cmp_arr[i]), .act(act_arr[i]), .pwm_mode(pwm_mode),
      .force_req(force_req[i]), .hit(hit[i]), .wave(wave[i]), .flag(flag[i])
    );
  end

  // only a real channel A hit may ask for a counter clear
  always_ff @(posedge clk) begin
    if (!rst_n) ctc_clr <= 1'b0;
    else        ctc_clr <= ctc_mode && !pwm_mode && hit[0];
  end

  assign wave_a  = wave[0];
  assign wave_b  = wave[1];
  assign match_a = flag[0];
  assign match_b = flag[1];

  assert_clr_needs_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctc_clr |-> match_a);
  assert_clr_not_pwm_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode || !ctc_mode) |=> !ctc_clr);
  assert_no_tick_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_tick |=> (!match_a && !match_b && !ctc_clr));
endmodule

// File: tb/sim_oc_wave_unit.sv
module sim_oc_wave_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_tick = 1'b0;
  logic [15:0] cnt_val = '0, cmp_a = 16'd100, cmp_b = 16'd200;
  logic [1:0] com_a = '0, com_b = '0;
  logic pwm_mode = 1'b0, ctc_mode = 1'b0, ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic wave_a, wave_b, match_a, match_b, ctc_clr;

  int checks = 0, fails = 0;
  logic ew [2];

  always #2 clk = ~clk;

  oc_wave_unit u0 (.*);

  function automatic logic nxt(input logic [1:0] m, input logic c);
    return (m == 2'b01) ? ~c : (m == 2'b10) ? 1'b0 : (m == 2'b11) ? 1'b1 : c;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic tk, input logic [15:0] cv, input logic wr,
                      input logic [7:0] wd, input string tag);
    logic h0, h1, f0, f1;
    cnt_tick = tk; cnt_val = cv; ctl_wr = wr; ctl_wdata = wd;
    #0;
    chk({"R8 rdata ", tag}, ctl_rdata, 8'h00);
    h0 = tk && cv == cmp_a; h1 = tk && cv == cmp_b;
    f0 = wr && wd[7]; f1 = wr && wd[6];
    if ((h0 || f0) && !pwm_mode) ew[0] = nxt(com_a, ew[0]);
    if ((h1 || f1) && !pwm_mode) ew[1] = nxt(com_b, ew[1]);
    @(posedge clk); @(negedge clk);
    cnt_tick = 0; ctl_wr = 0; ctl_wdata = '0;
    chk({"R3 R4 R7 R10 wave_a ", tag}, {7'd0, wave_a}, {7'd0, ew[0]});
    chk({"R3 R4 R7 R10 wave_b ", tag}, {7'd0, wave_b}, {7'd0, ew[1]});
    chk({"R2 R5 R12 match_a ", tag}, {7'd0, match_a}, {7'd0, h0});
    chk({"R2 R5 R12 match_b ", tag}, {7'd0, match_b}, {7'd0, h1});
    chk({"R6 R9 R11 ctc_clr ", tag}, {7'd0, ctc_clr},
        {7'd0, ctc_mode && !pwm_mode && h0});
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    ew[0] = 0; ew[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset waves", {6'd0, wave_b, wave_a}, 8'h00);
    chk("R1 reset flags", {5'd0, ctc_clr, match_b, match_a}, 8'h00);
    for (int p = 0; p < 2; p++)
      for (int c = 0; c < 2; c++)
        for (int ma = 0; ma < 4; ma++)
          for (int mb = 0; mb < 4; mb++)
            for (int s = 0; s < 6; s++) begin
              pwm_mode = p[0]; ctc_mode = c[0];
              com_a = ma[1:0]; com_b = mb[1:0];
              case (s)
                0: step(1, 16'd100, 0, 8'h00, "real hit A");
                1: step(1, 16'd200, 0, 8'h00, "real hit B");
                2: step(0, 16'd5,   1, 8'h80, "force A R6");
                3: step(1, 16'd7,   1, 8'h7F, "force B plus junk");
                4: step(1, 16'd100, 1, 8'hC0, "force both with hit A");
                default: step(0, 16'd200, 0, 8'h00, "equal without tick");
              endcase
            end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule